// File: doc/BRIEF.md
# Receive Queue Space Accounting Unit

This block keeps the byte count of received frame data held in a 4096-byte receive queue. Each time the receive path finishes storing a frame, it presents a one-cycle completion pulse together with the frame's stored size. The stored size covers the payload plus the per-frame status word. The block admits the frame only if the whole frame fits in the space still free. An admitted frame adds its size to a readable 13-bit count. A frame that does not fit is dropped whole, and a drop pulse is raised.

The host frees the oldest held frame by writing 1 to a release command bit. The release bit reads back as 1 for a fixed two-cycle window. When that window closes, the frame's size is subtracted from the count and the bit clears by itself. The sizes of admitted frames are kept in a small first-in first-out list, so each release returns exactly the space its frame used.

A sticky receive interrupt flag is set whenever the count rises with the interrupt enable set. The host clears the flag through a dedicated clear input.

Top module: `rxq_space_acct`

## Requirements
- R1: After synchronous reset, `avail_rd` is 0, and `rel_busy`, `rx_irq` and `frm_drop` are all 0.
- R2: A frame admitted on a `frm_done` pulse adds `frm_len` to the count, visible on `avail_rd[12:0]` from the clock edge that samples the pulse. `avail_rd[15:13]` always read 0.
- R3: A frame is admitted only when count + `frm_len` ≤ 4096, so a frame that fills the queue exactly is admitted. Otherwise the frame is dropped: `frm_drop` is 1 for exactly one cycle after the sampling edge, and the count does not change.
- R4: The size list holds 16 frames. A frame that arrives while 16 frames are held is dropped in the same way as in R3, even if it would fit.
- R5: A write with `rel_wr`=1 and `rel_wdata`=1, made while idle with at least one frame held, sets `rel_busy` for exactly two cycles. At the edge where `rel_busy` falls, the size of the oldest held frame is subtracted from the count, with frames released in arrival order.
- R6: A release write is ignored in three cases: while `rel_busy` is 1, when `rel_wdata`=0, and when no frame is held. An ignored write leaves `rel_busy` and the count unchanged.
- R7: An admitted frame sets `rx_irq` when `irq_en` is 1. It leaves `rx_irq` unchanged when `irq_en` is 0. A dropped frame never sets `rx_irq`.
- R8: `rx_irq` stays at 1 until a cycle with `irq_clr`=1 clears it. If a set and a clear fall on the same edge, the set wins.
- R9: If an admission and a release completion fall on the same edge, both take effect: the count becomes count + new size − released size. Admission is judged on the count held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | One-cycle pulse: a frame has been fully stored |
| frm_len | input | 13 | Stored size of that frame in bytes (payload plus status word) |
| rel_wr | input | 1 | Host write strobe to the release command register |
| rel_wdata | input | 1 | Write data bit 0 of the release command register (1 = release) |
| irq_en | input | 1 | Receive interrupt enable |
| irq_clr | input | 1 | Clears the sticky receive interrupt |
| avail_rd | output | 16 | Readable count: bits 12:0 hold bytes held, bits 15:13 read 0 |
| rel_busy | output | 1 | Release bit readback; 1 while a release is in progress |
| rx_irq | output | 1 | Sticky receive interrupt |
| frm_drop | output | 1 | One-cycle pulse: the last completed frame was discarded |

## Verification
Admission, drop and interrupt results are registered at the edge that samples `frm_done`. The bench drives every input on the falling edge and reads the result at the next falling edge, one edge later. After a release write, `rel_busy` is read at the two following falling edges and must be 1 both times. At the third falling edge `rel_busy` must be 0 and the reduced count must be visible. The combined case drives the new frame so that its pulse lands on the same edge as the release completion, and then checks the single combined count.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int CAP_BYTES   = 4096;
    localparam int CNT_W       = 13;
    localparam int REG_W       = 16;
    localparam int LEN_DEPTH   = 16;
    localparam int REL_LAT     = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic valid;
        cnt_t len;
    } frame_evt_t;

    typedef enum logic [1:0] {
        ADM_IDLE = 2'd0,
        ADM_TAKE = 2'd1,
        ADM_DROP = 2'd2
    } admit_t;

    // true when a frame of size len fits beside the bytes already held
    function automatic logic frame_fits(cnt_t held, cnt_t len);
        logic [CNT_W:0] sum;
        sum = {1'b0, held} + {1'b0, len};
        return sum <= (CNT_W+1)'(CAP_BYTES);
    endfunction

endpackage

// File: rtl/rxq_len_fifo.sv
module rxq_len_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = LEN_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  cnt_t push_len,
    input  logic pop,
    output cnt_t head_len,
    output logic empty,
    output logic full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    cnt_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;

    assign empty    = (occ == '0);
    assign full     = (occ == OCC_W'(DEPTH));
    assign head_len = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_len;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop) rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    p_no_push_full_r4: assert property (@(posedge clk) disable iff (rst)
        full && !pop |-> !push);
    p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

endmodule

// File: rtl/rxq_release_ctrl.sv
module rxq_release_ctrl
    import rxq_pkg::*;
#(
    parameter int LAT = REL_LAT
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wdata,
    input  logic have_frame,
    output logic busy,
    output logic pop
);
    localparam int TMR_W = (LAT > 1) ? $clog2(LAT) : 1;

    logic [TMR_W-1:0] tmr;
    logic             start;

    assign start = wr && wdata && !busy && have_frame;
    assign pop   = busy && (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tmr  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            tmr  <= TMR_W'(LAT - 1);
        end else if (busy) begin
            if (tmr == '0) busy <= 1'b0;
            else           tmr  <= tmr - 1'b1;
        end
    end

    p_busy_holds_r6: assert property (@(posedge clk) disable iff (rst)
        busy && !pop |=> busy);
    p_pop_ends_busy_r5: assert property (@(posedge clk) disable iff (rst)
        pop |=> !busy);
    p_idle_write_starts_r5: assert property (@(posedge clk) disable iff (rst)
        !busy && wr && wdata && have_frame |=> busy);

endmodule

// File: rtl/rxq_irq_flag.sv
module rxq_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        flag && !clr |=> flag);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

endmodule

// File: rtl/rxq_space_acct.sv
module rxq_space_acct
    import rxq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frm_done,
    input  logic [CNT_W-1:0]    frm_len,
    input  logic                rel_wr,
    input  logic                rel_wdata,
    input  logic                irq_en,
    input  logic                irq_clr,
    output logic [REG_W-1:0]    avail_rd,
    output logic                rel_busy,
    output logic                rx_irq,
    output logic                frm_drop
);
    frame_evt_t evt;
    admit_t     decision;
    cnt_t       held;
    cnt_t       head_len;
    logic       fifo_empty, fifo_full, pop;
    logic [CNT_W:0] nxt_held;

    assign evt.valid = frm_done;
    assign evt.len   = frm_len;

    always_comb begin
        if (!evt.valid)                                    decision = ADM_IDLE;
        else if (!fifo_full && frame_fits(held, evt.len))  decision = ADM_TAKE;
        else                                               decision = ADM_DROP;
    end

    rxq_len_fifo #(.DEPTH(LEN_DEPTH)) u_len_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (decision == ADM_TAKE),
        .push_len (evt.len),
        .pop      (pop),
        .head_len (head_len),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    rxq_release_ctrl #(.LAT(REL_LAT)) u_rel (
        .clk        (clk),
        .rst        (rst),
        .wr         (rel_wr),
        .wdata      (rel_wdata),
        .have_frame (!fifo_empty),
        .busy       (rel_busy),
        .pop        (pop)
    );

    rxq_irq_flag u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  ((decision == ADM_TAKE) && irq_en),
        .clr  (irq_clr),
        .flag (rx_irq)
    );

    always_comb begin
        nxt_held = {1'b0, held};
        if (decision == ADM_TAKE) nxt_held = nxt_held + {1'b0, evt.len};
        if (pop)                  nxt_held = nxt_held - {1'b0, head_len};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            frm_drop <= 1'b0;
        end else begin
            held     <= nxt_held[CNT_W-1:0];
            frm_drop <= (decision == ADM_DROP);
        end
    end

    assign avail_rd = {{(REG_W-CNT_W){1'b0}}, held};

    p_cap_r3: assert property (@(posedge clk) disable iff (rst)
        held <= cnt_t'(CAP_BYTES));
    p_drop_keeps_count_r3: assert property (@(posedge clk) disable iff (rst)
        (decision == ADM_DROP) && !pop |=> $stable(held));
    p_drop_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        frm_drop |=> !frm_drop || $past(frm_done));
    p_release_lowers_r5: assert property (@(posedge clk) disable iff (rst)
        pop && (decision != ADM_TAKE) |=> held <= $past(held));

endmodule

// File: tb/rxq_space_acct_tb.sv
module rxq_space_acct_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        frm_done, rel_wr, rel_wdata, irq_en, irq_clr;
    logic [12:0] frm_len;
    logic [15:0] avail_rd;
    logic        rel_busy, rx_irq, frm_drop;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_space_acct u_dut (
        .clk(clk), .rst(rst), .frm_done(frm_done), .frm_len(frm_len),
        .rel_wr(rel_wr), .rel_wdata(rel_wdata), .irq_en(irq_en),
        .irq_clr(irq_clr), .avail_rd(avail_rd), .rel_busy(rel_busy),
        .rx_irq(rx_irq), .frm_drop(frm_drop)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send(int len);
        frm_done = 1'b1;
        frm_len  = 13'(len);
        step();
        frm_done = 1'b0;
    endtask

    task automatic rel_write(bit data);
        rel_wr    = 1'b1;
        rel_wdata = data;
        step();
        rel_wr    = 1'b0;
        rel_wdata = 1'b0;
    endtask

    // full release with the busy window checked, then count
    task automatic release_one(int exp_after);
        rel_write(1'b1);
        check("R5 busy cycle 1", int'(rel_busy), 1);
        step();
        check("R5 busy cycle 2", int'(rel_busy), 1);
        step();
        check("R5 busy cleared", int'(rel_busy), 0);
        check("R5 count after release", int'(avail_rd), exp_after);
    endtask

    task automatic t_reset();
        check("R1 avail", int'(avail_rd), 0);
        check("R1 busy", int'(rel_busy), 0);
        check("R1 irq", int'(rx_irq), 0);
        check("R1 drop", int'(frm_drop), 0);
    endtask

    task automatic t_accept_no_irq();
        irq_en = 1'b0;
        send(100);
        check("R2 add 100", int'(avail_rd), 100);
        check("R7 no irq when disabled", int'(rx_irq), 0);
        send(200);
        check("R2 add 200", int'(avail_rd), 300);
        check("R2 reserved bits zero", int'(avail_rd[15:13]), 0);
    endtask

    task automatic t_irq();
        irq_en = 1'b1;
        send(50);
        check("R7 irq set", int'(rx_irq), 1);
        check("R2 add 50", int'(avail_rd), 350);
        step();
        check("R8 irq sticky", int'(rx_irq), 1);
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        check("R8 irq cleared", int'(rx_irq), 0);
        irq_clr = 1'b1;
        frm_done = 1'b1;
        frm_len = 13'd0;
        step();
        frm_done = 1'b0;
        irq_clr = 1'b0;
        check("R8 set wins over clear", int'(rx_irq), 1);
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        check("R8 irq cleared again", int'(rx_irq), 0);
    endtask

    // held sizes now: 100, 200, 50, 0
    task automatic t_release();
        release_one(250);
        rel_wr = 1'b1;
        rel_wdata = 1'b1;
        step();
        check("R6 busy after first write", int'(rel_busy), 1);
        step();
        rel_wr = 1'b0;
        rel_wdata = 1'b0;
        check("R6 second write ignored, still busy", int'(rel_busy), 1);
        step();
        check("R6 busy clears on schedule", int'(rel_busy), 0);
        check("R6 only one frame freed", int'(avail_rd), 50);
        step();
        check("R6 no restart", int'(rel_busy), 0);
        rel_write(1'b0);
        check("R6 data 0 ignored busy", int'(rel_busy), 0);
        check("R6 data 0 ignored count", int'(avail_rd), 50);
        release_one(0);
        release_one(0);
        rel_write(1'b1);
        check("R6 release with nothing held", int'(rel_busy), 0);
        check("R6 count stays 0", int'(avail_rd), 0);
    endtask

    task automatic t_full();
        irq_en = 1'b1;
        send(4000);
        send(96);
        check("R3 exact fit admitted", int'(avail_rd), 4096);
        check("R3 exact fit not dropped", int'(frm_drop), 0);
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        send(1);
        check("R3 overflow dropped", int'(frm_drop), 1);
        check("R3 count unchanged", int'(avail_rd), 4096);
        check("R7 drop sets no irq", int'(rx_irq), 0);
        step();
        check("R3 drop pulse one cycle", int'(frm_drop), 0);
        release_one(96);
        release_one(0);
    endtask

    task automatic t_list_full();
        for (int i = 0; i < 16; i++) send(10);
        check("R4 sixteen held", int'(avail_rd), 160);
        send(10);
        check("R4 seventeenth dropped", int'(frm_drop), 1);
        check("R4 count unchanged", int'(avail_rd), 160);
        for (int i = 15; i >= 0; i--) release_one(i * 10);
    endtask

    task automatic t_concurrent();
        send(300);
        rel_wr = 1'b1;
        rel_wdata = 1'b1;
        step();
        rel_wr = 1'b0;
        rel_wdata = 1'b0;
        step();
        send(20);
        check("R9 combined count", int'(avail_rd), 20);
        check("R9 release done", int'(rel_busy), 0);
        release_one(0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        frm_done = 1'b0;
        frm_len = '0;
        rel_wr = 1'b0;
        rel_wdata = 1'b0;
        irq_en = 1'b0;
        irq_clr = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_accept_no_irq();
        t_irq();
        t_release();
        t_full();
        t_list_full();
        t_concurrent();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule